// File: doc/BRIEF.md
# Configuration Request Router with Secondary-Bus Bridge

This block takes configuration read and write requests from a host and decides where each one lands. The 24-bit request address is split into a bus number, a device/function byte and a register offset. Requests for bus 0 are sent to local device slots or to the bridge's own small configuration header. Requests whose bus number equals the bridge's programmed secondary bus number are passed downstream unchanged. Anything else is dropped.

The secondary bus number is not fixed. It is written at run time through the bridge's own header, and every later request is steered by the new value. The bridge header also reports a set of fixed identity bytes. Each accepted request produces at most one select pulse and exactly one response strobe, one cycle after acceptance.

The parameter BRIDGE_DEV must be at least NUM_SLOTS so that the bridge does not overlap a local slot.

Top module: `cfg_bridge_router`

## Requirements
- R1: The address splits as bus = reqAddr[23:16], device = reqAddr[15:11], function = reqAddr[10:8] and offset = reqAddr[7:0]. A request on bus 0 with function 0 and device i, where i < NUM_SLOTS and PRESENT_MASK[i] is set, drives slotSel[i].
- R2: A request is accepted in any cycle with reqValid high. In the following cycle respValid is high for exactly that cycle. At most one of slotSel/fwdSel is high in that same cycle. busAddr, busData, busWrite and busLen carry the accepted request in that cycle.
- R3: A request whose bus number is nonzero and equals the secondary bus number drives fwdSel. A read of this kind returns fwdRdData as respData.
- R4: The following requests are dropped with no select: a request to an unmatched bus, an absent slot, a nonzero function on bus 0, or a device that is neither a slot nor the bridge. A dropped read returns 32'hFFFFFFFF.
- R5: The bridge sits at device BRIDGE_DEV, function 0, on bus 0. Its header reads as follows:
  - vendor ID at offsets 0x00–0x01 and device ID at 0x02–0x03
  - 0x06 at offset 0x04 and 0xA0 at 0x06
  - 0x04 at 0x0A and 0x06 at 0x0B (class 0x0604)
  - 0x10 at 0x0D and 0x81 at 0x0E
  - the secondary bus number at 0x19 and 0xA0 at 0x1E
  - zero at every other offset.
- R6: A bridge write at offset 0x19, of any length, loads the secondary bus number from reqData[7:0].
- R7: A bridge write at offset 0x18 with length code nonzero (2 or 4 bytes) loads the secondary bus number from reqData[15:8]. A 1-byte write at 0x18 has no effect.
- R8: All other bridge writes leave the header unchanged.
- R9: The secondary bus number is 0 after reset, so no request is forwarded. A new value steers a request accepted in the very next cycle. Bus 0 is always local.
- R10: reqLen codes the access length: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Bridge reads return the header bytes starting at the offset, little-endian, with the offset wrapping modulo 256 and unused upper bytes zero. Slot reads return slotRdData. Every write response carries respData = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLen | input | 2 | Access length code |
| reqAddr | input | 24 | Bus / device-function / offset address |
| reqData | input | 32 | Write data |
| slotSel | output | NUM_SLOTS | One-cycle select per local slot |
| fwdSel | output | 1 | One-cycle downstream forward select |
| busAddr | output | 24 | Registered request address |
| busWrite | output | 1 | Registered write flag |
| busLen | output | 2 | Registered length code |
| busData | output | 32 | Registered write data |
| slotRdData | input | 32 | Read data from the selected local slot |
| fwdRdData | input | 32 | Read data from downstream |
| respValid | output | 1 | One-cycle response strobe |
| respData | output | 32 | Response data |

## Verification
A corrupted secondary bus number shows up on the first later request to the old or the new bus. That request either raises fwdSel wrongly or is answered with all ones one cycle after acceptance. A read of offset 0x18 exposes the stored value directly in the same cycle. A wrong route decision appears as a wrong select bit or a wrong data source on respData in the cycle after the request. A lost or doubled strobe is visible as respValid high on the idle cycle that follows each request.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  typedef enum logic [1:0] {
    SRC_MISS   = 2'd0,
    SRC_SLOT   = 2'd1,
    SRC_FWD    = 2'd2,
    SRC_BRIDGE = 2'd3
  } route_src_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       valid;
    route_src_t kind;
    logic       secLoadLo;  // load from data[7:0]
    logic       secLoadHi;  // load from data[15:8]
  } route_stb_t;

  localparam logic [7:0] OFF_SEC_BUS = 8'h19;
  localparam logic [7:0] OFF_BUS_DW  = 8'h18;

  // One byte of the bridge header
  function automatic logic [7:0] hdrByte(input logic [7:0] off,
                                         input logic [7:0] secBus,
                                         input logic [15:0] vendorId,
                                         input logic [15:0] deviceId);
    logic [7:0] b;
    case (off)
      8'h00:   b = vendorId[7:0];
      8'h01:   b = vendorId[15:8];
      8'h02:   b = deviceId[7:0];
      8'h03:   b = deviceId[15:8];
      8'h04:   b = 8'h06;
      8'h06:   b = 8'hA0;
      8'h0A:   b = 8'h04;
      8'h0B:   b = 8'h06;
      8'h0D:   b = 8'h10;
      8'h0E:   b = 8'h81;
      8'h19:   b = secBus;
      8'h1E:   b = 8'hA0;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cfg_router_ctrl.sv
module cfg_router_ctrl
  import cfg_router_pkg::*;
#(
  parameter int                   NUM_SLOTS    = 4,
  parameter int                   BRIDGE_DEV   = 5,
  parameter logic [NUM_SLOTS-1:0] PRESENT_MASK = '1
) (
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqLen,
  input  logic [23:0]          reqAddr,
  input  logic [7:0]           secBus,
  output logic [NUM_SLOTS-1:0] slotHit,
  output route_stb_t           stb
);

  localparam int DEV_W = 5;

  logic [7:0]       busNum;
  logic [DEV_W-1:0] devNum;
  logic [2:0]       fnNum;
  logic [7:0]       offset;
  logic             busZero;
  logic             bridgeHit;
  logic             fwdHit;
  logic             bridgeWrite;

  assign busNum  = reqAddr[23:16];
  assign devNum  = reqAddr[15:11];
  assign fnNum   = reqAddr[10:8];
  assign offset  = reqAddr[7:0];
  assign busZero = (busNum == 8'd0);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slotHit[i] = reqValid && busZero && (fnNum == 3'd0) &&
                        (devNum == DEV_W'(i)) && PRESENT_MASK[i];
  end

  assign bridgeHit   = busZero && (fnNum == 3'd0) && (devNum == DEV_W'(BRIDGE_DEV));
  assign fwdHit      = !busZero && (busNum == secBus);
  assign bridgeWrite = reqValid && reqWrite && bridgeHit;

  always_comb begin
    stb.valid     = reqValid;
    stb.secLoadLo = bridgeWrite && (offset == OFF_SEC_BUS);
    stb.secLoadHi = bridgeWrite && (offset == OFF_BUS_DW) && (reqLen != 2'd0);
    if (|slotHit)       stb.kind = SRC_SLOT;
    else if (bridgeHit) stb.kind = SRC_BRIDGE;
    else if (fwdHit)    stb.kind = SRC_FWD;
    else                stb.kind = SRC_MISS;
  end

endmodule

// File: rtl/cfg_router_dp.sv
module cfg_router_dp
  import cfg_router_pkg::*;
#(
  parameter int          NUM_SLOTS = 4,
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID = 16'h7E01
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqLen,
  input  logic [23:0]          reqAddr,
  input  logic [31:0]          reqData,
  input  logic [NUM_SLOTS-1:0] slotHit,
  input  route_stb_t           stb,
  input  logic [31:0]          slotRdData,
  input  logic [31:0]          fwdRdData,
  output logic [7:0]           secBus,
  output logic [NUM_SLOTS-1:0] slotSel,
  output logic                 fwdSel,
  output logic [23:0]          busAddr,
  output logic                 busWrite,
  output logic [1:0]           busLen,
  output logic [31:0]          busData,
  output logic                 respValid,
  output logic [31:0]          respData
);

  localparam int BYTES = 4;

  logic [7:0]           secBusQ;
  logic [NUM_SLOTS-1:0] slotSelQ;
  logic                 fwdSelQ;
  logic                 respValidQ;
  logic [23:0]          busAddrQ;
  logic [31:0]          busDataQ;
  logic                 busWriteQ;
  logic [1:0]           busLenQ;
  route_src_t           srcQ;
  logic [31:0]          bridgeRdQ;
  logic [31:0]          bridgeRd;
  logic [BYTES-1:0]     byteEn;

  // byte enables from the length code
  assign byteEn[0] = 1'b1;
  assign byteEn[1] = (reqLen != 2'd0);
  assign byteEn[2] = reqLen[1];
  assign byteEn[3] = reqLen[1];

  for (genvar b = 0; b < BYTES; b++) begin : g_hdr
    assign bridgeRd[8*b +: 8] = byteEn[b] ?
      hdrByte(reqAddr[7:0] + 8'(b), secBusQ, VENDOR_ID, DEVICE_ID) : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secBusQ    <= 8'd0;
      slotSelQ   <= '0;
      fwdSelQ    <= 1'b0;
      respValidQ <= 1'b0;
      busAddrQ   <= '0;
      busDataQ   <= '0;
      busWriteQ  <= 1'b0;
      busLenQ    <= '0;
      srcQ       <= SRC_MISS;
      bridgeRdQ  <= '0;
    end else begin
      respValidQ <= stb.valid;
      slotSelQ   <= (stb.valid && stb.kind == SRC_SLOT) ? slotHit : '0;
      fwdSelQ    <= stb.valid && (stb.kind == SRC_FWD);
      if (stb.valid) begin
        busAddrQ  <= reqAddr;
        busDataQ  <= reqData;
        busWriteQ <= reqWrite;
        busLenQ   <= reqLen;
        srcQ      <= stb.kind;
        bridgeRdQ <= bridgeRd;
      end
      if (stb.secLoadLo)      secBusQ <= reqData[7:0];
      else if (stb.secLoadHi) secBusQ <= reqData[15:8];
    end
  end

  always_comb begin
    respData = '0;
    if (respValidQ && !busWriteQ) begin
      case (srcQ)
        SRC_SLOT:   respData = slotRdData;
        SRC_FWD:    respData = fwdRdData;
        SRC_BRIDGE: respData = bridgeRdQ;
        default:    respData = '1;
      endcase
    end
  end

  assign secBus    = secBusQ;
  assign slotSel   = slotSelQ;
  assign fwdSel    = fwdSelQ;
  assign respValid = respValidQ;
  assign busAddr   = busAddrQ;
  assign busData   = busDataQ;
  assign busWrite  = busWriteQ;
  assign busLen    = busLenQ;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({slotSelQ, fwdSelQ})); // R2
  AST_SEL_HAS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (|slotSelQ || fwdSelQ) |-> respValidQ); // R2
  AST_RESP_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    respValidQ |-> $past(reqValid)); // R2
  AST_FWD_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    fwdSelQ |-> (busAddrQ[23:16] == secBusQ && secBusQ != 8'd0)); // R3
  AST_LOCAL_BUS0: assert property (@(posedge clk) disable iff (!rstN)
    (|slotSelQ) |-> (busAddrQ[23:16] == 8'd0 && busAddrQ[10:8] == 3'd0)); // R1
  AST_SEC_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.secLoadLo || stb.secLoadHi) |=> $stable(secBusQ)); // R8

endmodule

// File: rtl/cfg_bridge_router.sv
module cfg_bridge_router
  import cfg_router_pkg::*;
#(
  parameter int                   NUM_SLOTS    = 4,
  parameter int                   BRIDGE_DEV   = 5,
  parameter logic [NUM_SLOTS-1:0] PRESENT_MASK = 4'b1011,
  parameter logic [15:0]          VENDOR_ID    = 16'hA5C3,
  parameter logic [15:0]          DEVICE_ID    = 16'h7E01
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqLen,
  input  logic [23:0]          reqAddr,
  input  logic [31:0]          reqData,
  output logic [NUM_SLOTS-1:0] slotSel,
  output logic                 fwdSel,
  output logic [23:0]          busAddr,
  output logic                 busWrite,
  output logic [1:0]           busLen,
  output logic [31:0]          busData,
  input  logic [31:0]          slotRdData,
  input  logic [31:0]          fwdRdData,
  output logic                 respValid,
  output logic [31:0]          respData
);

  logic [NUM_SLOTS-1:0] slotHit;
  route_stb_t           stb;
  logic [7:0]           secBus;

  cfg_router_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .BRIDGE_DEV(BRIDGE_DEV), .PRESENT_MASK(PRESENT_MASK)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLen(reqLen),
    .reqAddr(reqAddr), .secBus(secBus), .slotHit(slotHit), .stb(stb)
  );

  cfg_router_dp #(
    .NUM_SLOTS(NUM_SLOTS), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLen(reqLen), .reqAddr(reqAddr), .reqData(reqData),
    .slotHit(slotHit), .stb(stb), .slotRdData(slotRdData),
    .fwdRdData(fwdRdData), .secBus(secBus), .slotSel(slotSel),
    .fwdSel(fwdSel), .busAddr(busAddr), .busWrite(busWrite),
    .busLen(busLen), .busData(busData), .respValid(respValid),
    .respData(respData)
  );

endmodule

// File: tb/cfg_bridge_router_bench.sv
module cfg_bridge_router_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqLen = 2'd0;
  logic [23:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [3:0]  slotSel;
  logic        fwdSel;
  logic [23:0] busAddr;
  logic        busWrite;
  logic [1:0]  busLen;
  logic [31:0] busData;
  logic [31:0] slotRdData;
  logic [31:0] fwdRdData;
  logic        respValid;
  logic [31:0] respData;

  int nTests = 0;
  int nFail  = 0;

  always #5 clk = ~clk;

  // slot and downstream models
  assign slotRdData = 32'h5A000000 | {28'h0, slotSel};
  assign fwdRdData  = fwdSel ? (32'hF00D0000 | {16'h0, busAddr[15:0]}) : 32'h0;

  cfg_bridge_router u_cfg_bridge_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLen(reqLen), .reqAddr(reqAddr), .reqData(reqData),
    .slotSel(slotSel), .fwdSel(fwdSel), .busAddr(busAddr),
    .busWrite(busWrite), .busLen(busLen), .busData(busData),
    .slotRdData(slotRdData), .fwdRdData(fwdRdData),
    .respValid(respValid), .respData(respData)
  );

  // {wr, len, addr, data, kind(0 miss,1 slot,2 fwd,3 bridge), slot, expected}
  localparam int NVEC = 33;
  localparam logic [94:0] VEC [NVEC] = '{
    {1'b0, 2'd1, 24'h000010, 32'h0,        2'd1, 2'd0, 32'h5A000001}, // R1
    {1'b0, 2'd2, 24'h000804, 32'h0,        2'd1, 2'd1, 32'h5A000002}, // R1
    {1'b0, 2'd2, 24'h001800, 32'h0,        2'd1, 2'd3, 32'h5A000008}, // R1
    {1'b0, 2'd2, 24'h001000, 32'h0,        2'd0, 2'd0, 32'hFFFFFFFF}, // R4 absent
    {1'b0, 2'd2, 24'h000900, 32'h0,        2'd0, 2'd0, 32'hFFFFFFFF}, // R4 fn1
    {1'b0, 2'd2, 24'h002000, 32'h0,        2'd0, 2'd0, 32'hFFFFFFFF}, // R4 dev4
    {1'b0, 2'd2, 24'h002808, 32'h0,        2'd3, 2'd0, 32'h06040000}, // R5
    {1'b0, 2'd2, 24'h002804, 32'h0,        2'd3, 2'd0, 32'h00A00006}, // R5
    {1'b0, 2'd2, 24'h00280C, 32'h0,        2'd3, 2'd0, 32'h00811000}, // R5
    {1'b0, 2'd2, 24'h002800, 32'h0,        2'd3, 2'd0, 32'h7E01A5C3}, // R5
    {1'b0, 2'd2, 24'h030000, 32'h0,        2'd0, 2'd0, 32'hFFFFFFFF}, // R9
    {1'b1, 2'd0, 24'h002819, 32'h00000003, 2'd3, 2'd0, 32'h0},        // R6
    {1'b0, 2'd2, 24'h002818, 32'h0,        2'd3, 2'd0, 32'h00000300}, // R6
    {1'b0, 2'd2, 24'h030804, 32'h0,        2'd2, 2'd0, 32'hF00D0804}, // R3
    {1'b0, 2'd2, 24'h040000, 32'h0,        2'd0, 2'd0, 32'hFFFFFFFF}, // R4
    {1'b1, 2'd1, 24'h002818, 32'h00000900, 2'd3, 2'd0, 32'h0},        // R7
    {1'b0, 2'd2, 24'h090040, 32'h0,        2'd2, 2'd0, 32'hF00D0040}, // R7
    {1'b0, 2'd2, 24'h030000, 32'h0,        2'd0, 2'd0, 32'hFFFFFFFF}, // R7
    {1'b1, 2'd0, 24'h002818, 32'h00000500, 2'd3, 2'd0, 32'h0},        // R7 1-byte
    {1'b0, 2'd1, 24'h002818, 32'h0,        2'd3, 2'd0, 32'h00000900}, // R7
    {1'b0, 2'd0, 24'h00281E, 32'h0,        2'd3, 2'd0, 32'h000000A0}, // R5
    {1'b1, 2'd0, 24'h002804, 32'h000000FF, 2'd3, 2'd0, 32'h0},        // R8
    {1'b0, 2'd0, 24'h002804, 32'h0,        2'd3, 2'd0, 32'h00000006}, // R8
    {1'b0, 2'd1, 24'h00280A, 32'h0,        2'd3, 2'd0, 32'h00000604}, // R10
    {1'b0, 2'd0, 24'h00280E, 32'h0,        2'd3, 2'd0, 32'h00000081}, // R10
    {1'b1, 2'd2, 24'h001808, 32'h12345678, 2'd1, 2'd3, 32'h0},        // R10
    {1'b1, 2'd2, 24'h090000, 32'hCAFE0001, 2'd2, 2'd0, 32'h0},        // R3
    {1'b0, 2'd0, 24'h09FF00, 32'h0,        2'd2, 2'd0, 32'hF00DFF00}, // R3
    {1'b1, 2'd3, 24'h002819, 32'hAABBCC00, 2'd3, 2'd0, 32'h0},        // R6
    {1'b0, 2'd2, 24'h090000, 32'h0,        2'd0, 2'd0, 32'hFFFFFFFF}, // R9
    {1'b0, 2'd2, 24'h000000, 32'h0,        2'd1, 2'd0, 32'h5A000001}, // R9
    {1'b0, 2'd2, 24'h002818, 32'h0,        2'd3, 2'd0, 32'h00000000}, // R6
    {1'b0, 2'd2, 24'h0028FE, 32'h0,        2'd3, 2'd0, 32'hA5C30000}  // R10
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [1:0] len,
                       input logic [23:0] addr, input logic [31:0] data);
    reqValid = 1'b1; reqWrite = wr; reqLen = len; reqAddr = addr; reqData = data;
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(respValid == 1'b0 && slotSel == 4'd0 && fwdSel == 1'b0, "R9 reset outputs idle",
          {28'h0, slotSel}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [94:0] e;
      logic [3:0]  expSel;
      e = VEC[v];
      expSel = (e[35:34] == 2'd1) ? (4'd1 << e[33:32]) : 4'd0;
      drive(e[94], e[93:92], e[91:68], e[67:36]);
      @(negedge clk);
      reqValid = 1'b0;
      check(respValid == 1'b1, $sformatf("R2 vec%0d strobe", v), {31'h0, respValid}, 32'h1);
      check(slotSel == expSel, $sformatf("R1/R4 vec%0d slotSel", v), {28'h0, slotSel}, {28'h0, expSel});
      check(fwdSel == (e[35:34] == 2'd2), $sformatf("R3 vec%0d fwdSel", v), {31'h0, fwdSel},
            {31'h0, e[35:34] == 2'd2});
      check(respData == e[31:0], $sformatf("R10 vec%0d respData", v), respData, e[31:0]);
      check(busAddr == e[91:68] && busWrite == e[94], $sformatf("R2 vec%0d bus fields", v),
            {8'h0, busAddr}, {8'h0, e[91:68]});
      @(negedge clk);
      check(respValid == 1'b0 && slotSel == 4'd0 && !fwdSel, $sformatf("R2 vec%0d idle", v),
            {31'h0, respValid}, 32'h0);
    end

    // R9 back-to-back: new bus number steers the next-cycle request
    drive(1'b1, 2'd0, 24'h002819, 32'h00000007);
    @(negedge clk);
    check(respValid == 1'b1 && respData == 32'h0, "R6 b2b write resp", respData, 32'h0);
    drive(1'b0, 2'd2, 24'h070C20, 32'h0);
    @(negedge clk);
    reqValid = 1'b0;
    check(fwdSel == 1'b1, "R9 b2b forward", {31'h0, fwdSel}, 32'h1);
    check(respData == 32'hF00D0C20, "R9 b2b data", respData, 32'hF00D0C20);
    check(busData == 32'h0 && busLen == 2'd2, "R2 b2b bus len", {30'h0, busLen}, 32'h2);
    @(negedge clk);
    check(respValid == 1'b0 && fwdSel == 1'b0, "R2 single pulse", {31'h0, respValid}, 32'h0);

    // R9 reset clears the secondary bus number
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    drive(1'b0, 2'd2, 24'h070000, 32'h0);
    @(negedge clk);
    reqValid = 1'b0;
    check(fwdSel == 1'b0 && respData == 32'hFFFFFFFF, "R9 after reset miss", respData, 32'hFFFFFFFF);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule